// File: doc/BRIEF.md
# Universal bus transceiver datapath

This block moves data between an A bus and a B bus in both directions. Each direction has its own active-low output enable, its own latch enable and its own direction clock. Data can pass straight through, be frozen in place, or be captured on a rising edge of the direction clock. The three behaviours share one storage register per lane and direction. All of it runs in the core clock domain. The direction clocks are treated as slow control inputs: each is synchronised and edge-detected.

The data width is a parameter. A mode parameter chooses between two layouts. In the first, the block is one full-width transceiver steered by control set 0. In the second, it is two independent half-width transceivers, where control set 0 owns the lower half and control set 1 owns the upper half. Three-state pads are represented by the data value plus a drive-enable for each lane and direction. A single test-inhibit input freezes all transfers and releases both buses. A contention flag reports any lane whose two directions would drive at the same time.

Top module: `ubt_xcvr`

## Requirements
- R1: While rst_ni is low, both data outputs are all zero, every drive-enable is low and contention_o is low.
- R2: With latch enable high, a lane's destination output takes the source input value present at each core clock edge, one cycle after that edge.
- R3: With latch enable low and a steady direction clock (held high or held low), the destination output keeps its value even when the source input changes.
- R4: With latch enable low, a low-to-high change of the direction clock stores the source input. The new value appears at the output no later than four core cycles after the change.
- R5: A high-to-low change of the direction clock with latch enable low stores nothing.
- R6: The drive-enable of a lane and direction is high on the cycle after its active-low output enable was low, and low on the cycle after it was high.
- R7: The B-to-A direction behaves like A-to-B and uses only its own output enable, latch enable and direction clock.
- R8: In split mode (MODE_SPLIT), control bit 0 acts on data bits [W/2-1:0] and control bit 1 acts on bits [W-1:W/2]. Each half is independent of the other half's controls.
- R9: In full mode (MODE_FULL), control bit 0 steers the whole width and both drive-enables, and control bit 1 has no effect.
- R10: While test_inhibit_i is high, no storage loads (including on direction-clock edges), and every drive-enable is low on the following cycle.
- R11: contention_o is high whenever some lane has both its A-to-B and its B-to-A drive-enable high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| test_inhibit_i | input | 1 | Blocks every transfer and releases both buses |
| a_data_i | input | W | Value present on the A bus |
| b_data_i | input | W | Value present on the B bus |
| oe_ab_ni | input | 2 | A-to-B output enable per control set, active low |
| le_ab_i | input | 2 | A-to-B latch enable per control set |
| ck_ab_i | input | 2 | A-to-B direction clock per control set |
| oe_ba_ni | input | 2 | B-to-A output enable per control set, active low |
| le_ba_i | input | 2 | B-to-A latch enable per control set |
| ck_ba_i | input | 2 | B-to-A direction clock per control set |
| b_data_o | output | W | Value driven toward the B bus |
| b_drive_o | output | 2 | Per-lane B bus drive-enable |
| a_data_o | output | W | Value driven toward the A bus |
| a_drive_o | output | 2 | Per-lane A bus drive-enable |
| contention_o | output | 1 | Some lane drives both buses at once |

## Verification
Every storage register feeds a data output directly, so a wrong load condition is visible on the destination bus one core cycle after it happens. A capture that was missed or spurious shows within four cycles of the direction-clock change. A lane decoded from the wrong control set shows as one half of the bus moving while its own controls say hold. The full-mode instance is driven with the same stimulus to make that difference observable. A drive-enable or contention error appears on the cycle after the output-enable change that caused it.

// File: rtl/ubt_pkg.sv
package ubt_pkg;
  localparam int LANES = 2;

  typedef enum logic {
    MODE_FULL  = 1'b0,
    MODE_SPLIT = 1'b1
  } width_mode_e;
endpackage

// File: rtl/ubt_edge.sv
module ubt_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], async_i};
  end

  // synchronised level is sh_q[STAGES-1]; sh_q[STAGES] is its previous value
  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/ubt_store.sv
module ubt_store #(
  parameter int W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inhibit_i,
  input  logic         le_i,
  input  logic         rise_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic load;
  assign load = ~inhibit_i & (le_i | rise_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (load) q_o <= d_i;
  end
endmodule

// File: rtl/ubt_dir.sv
module ubt_dir
  import ubt_pkg::*;
#(
  parameter int          W      = 18,
  parameter width_mode_e MODE   = MODE_SPLIT,
  parameter int          STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inhibit_i,
  input  logic [LANES-1:0] oe_ni,
  input  logic [LANES-1:0] le_i,
  input  logic [LANES-1:0] ck_i,
  input  logic [W-1:0]     d_i,
  output logic [W-1:0]     q_o,
  output logic [LANES-1:0] drive_o
);
  localparam int LW    = W / LANES;
  localparam int NCTRL = (MODE == MODE_SPLIT) ? LANES : 1;

  logic [NCTRL-1:0] rise;

  for (genvar c = 0; c < NCTRL; c++) begin : g_ctrl
    ubt_edge #(.STAGES(STAGES)) u_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .async_i(ck_i[c]),
      .rise_o (rise[c])
    );
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam int C = (MODE == MODE_SPLIT) ? l : 0;

    ubt_store #(.W(LW)) u_store (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .inhibit_i(inhibit_i),
      .le_i     (le_i[C]),
      .rise_i   (rise[C]),
      .d_i      (d_i[l*LW +: LW]),
      .q_o      (q_o[l*LW +: LW])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) drive_o[l] <= 1'b0;
      else         drive_o[l] <= ~inhibit_i & ~oe_ni[C];
    end
  end
endmodule

// File: rtl/ubt_xcvr.sv
module ubt_xcvr
  import ubt_pkg::*;
#(
  parameter int          W      = 18,
  parameter width_mode_e MODE   = MODE_SPLIT,
  parameter int          STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             test_inhibit_i,
  input  logic [W-1:0]     a_data_i,
  input  logic [W-1:0]     b_data_i,
  input  logic [LANES-1:0] oe_ab_ni,
  input  logic [LANES-1:0] le_ab_i,
  input  logic [LANES-1:0] ck_ab_i,
  input  logic [LANES-1:0] oe_ba_ni,
  input  logic [LANES-1:0] le_ba_i,
  input  logic [LANES-1:0] ck_ba_i,
  output logic [W-1:0]     b_data_o,
  output logic [LANES-1:0] b_drive_o,
  output logic [W-1:0]     a_data_o,
  output logic [LANES-1:0] a_drive_o,
  output logic             contention_o
);
  ubt_dir #(.W(W), .MODE(MODE), .STAGES(STAGES)) u_ab (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .inhibit_i(test_inhibit_i),
    .oe_ni    (oe_ab_ni),
    .le_i     (le_ab_i),
    .ck_i     (ck_ab_i),
    .d_i      (a_data_i),
    .q_o      (b_data_o),
    .drive_o  (b_drive_o)
  );

  ubt_dir #(.W(W), .MODE(MODE), .STAGES(STAGES)) u_ba (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .inhibit_i(test_inhibit_i),
    .oe_ni    (oe_ba_ni),
    .le_i     (le_ba_i),
    .ck_i     (ck_ba_i),
    .d_i      (b_data_i),
    .q_o      (a_data_o),
    .drive_o  (a_drive_o)
  );

  assign contention_o = |(a_drive_o & b_drive_o);
endmodule

// File: rtl/ubt_xcvr_chk.sv
module ubt_xcvr_chk #(
  parameter int W = 18
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         test_inhibit_i,
  input logic [W-1:0] a_data_i,
  input logic [1:0]   oe_ab_ni,
  input logic [1:0]   le_ab_i,
  input logic [1:0]   oe_ba_ni,
  input logic [W-1:0] b_data_o,
  input logic [1:0]   b_drive_o,
  input logic [W-1:0] a_data_o,
  input logic [1:0]   a_drive_o,
  input logic         contention_o
);
  localparam int H = W / 2;

  logic armed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  AST_TRANSPARENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && $past(le_ab_i[0] && !test_inhibit_i) |-> b_data_o[H-1:0] == $past(a_data_i[H-1:0])); // R2

  AST_DRIVE_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && $past(!oe_ab_ni[0] && !test_inhibit_i) |-> b_drive_o[0]); // R6

  AST_DRIVE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && $past(oe_ab_ni[0]) |-> !b_drive_o[0]); // R6

  AST_INHIBIT_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && $past(test_inhibit_i) |-> (a_drive_o == 2'b00) && (b_drive_o == 2'b00)); // R10

  AST_INHIBIT_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && $past(test_inhibit_i) |-> $stable(b_data_o) && $stable(a_data_o)); // R10

  AST_CONTENTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && $past(!oe_ab_ni[0] && !oe_ba_ni[0] && !test_inhibit_i) |-> contention_o); // R11
endmodule

bind ubt_xcvr ubt_xcvr_chk #(.W(W)) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .test_inhibit_i(test_inhibit_i),
  .a_data_i      (a_data_i),
  .oe_ab_ni      (oe_ab_ni),
  .le_ab_i       (le_ab_i),
  .oe_ba_ni      (oe_ba_ni),
  .b_data_o      (b_data_o),
  .b_drive_o     (b_drive_o),
  .a_data_o      (a_data_o),
  .a_drive_o     (a_drive_o),
  .contention_o  (contention_o)
);

// File: tb/ubt_xcvr_tb_top.sv
module ubt_xcvr_tb_top;
  import ubt_pkg::*;

  localparam int W = 18;
  localparam int H = W / 2;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inhibit = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [1:0] oe_ab_n = 2'b11, le_ab = 2'b00, ck_ab = 2'b00;
  logic [1:0] oe_ba_n = 2'b11, le_ba = 2'b00, ck_ba = 2'b00;

  logic [W-1:0] b_out, a_out, fb_out, fa_out;
  logic [1:0]   b_drv, a_drv, fb_drv, fa_drv;
  logic         cont, fcont;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ubt_xcvr #(.W(W), .MODE(MODE_SPLIT)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .test_inhibit_i(inhibit),
    .a_data_i(a_in), .b_data_i(b_in),
    .oe_ab_ni(oe_ab_n), .le_ab_i(le_ab), .ck_ab_i(ck_ab),
    .oe_ba_ni(oe_ba_n), .le_ba_i(le_ba), .ck_ba_i(ck_ba),
    .b_data_o(b_out), .b_drive_o(b_drv), .a_data_o(a_out), .a_drive_o(a_drv),
    .contention_o(cont)
  );

  ubt_xcvr #(.W(W), .MODE(MODE_FULL)) dut_full_i (
    .clk_i(clk), .rst_ni(rst_n), .test_inhibit_i(inhibit),
    .a_data_i(a_in), .b_data_i(b_in),
    .oe_ab_ni(oe_ab_n), .le_ab_i(le_ab), .ck_ab_i(ck_ab),
    .oe_ba_ni(oe_ba_n), .le_ba_i(le_ba), .ck_ba_i(ck_ba),
    .b_data_o(fb_out), .b_drive_o(fb_drv), .a_data_o(fa_out), .a_drive_o(fa_drv),
    .contention_o(fcont)
  );

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    step(2);
    check("R1 b_data", b_out, '0);
    check("R1 a_data", a_out, '0);
    check("R1 drives", {14'd0, b_drv, a_drv}, '0);
    check("R1 contention", {17'd0, cont}, '0);
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic t_transparent;
    oe_ab_n = 2'b00; le_ab = 2'b11; a_in = 18'h2A5C3;
    step(1);
    check("R2 first", b_out, 18'h2A5C3);
    check("R6 drive on", {16'd0, b_drv}, 18'd3);
    a_in = 18'h1B7E0;
    step(1);
    check("R2 second", b_out, 18'h1B7E0);
    check("R2 full inst", fb_out, 18'h1B7E0);
  endtask

  task automatic t_hold_capture;
    le_ab = 2'b00; a_in = 18'h0F0F0;
    step(3);
    check("R3 hold low clk", b_out, 18'h1B7E0);
    ck_ab = 2'b11;
    step(4);
    check("R4 capture", b_out, 18'h0F0F0);
    check("R4 full inst", fb_out, 18'h0F0F0);
    a_in = 18'h33333;
    step(3);
    check("R3 hold high clk", b_out, 18'h0F0F0);
    ck_ab = 2'b00;
    step(4);
    check("R5 falling edge", b_out, 18'h0F0F0);
  endtask

  task automatic t_drive_off;
    oe_ab_n = 2'b11;
    step(1);
    check("R6 drive off", {16'd0, b_drv}, '0);
    check("R6 full drive off", {16'd0, fb_drv}, '0);
  endtask

  task automatic t_b_to_a;
    oe_ba_n = 2'b00; le_ba = 2'b11; b_in = 18'h35A5A;
    step(1);
    check("R7 transparent", a_out, 18'h35A5A);
    check("R7 drive", {14'd0, a_drv, b_drv}, {14'd0, 2'b11, 2'b00});
    check("R7 b side untouched", b_out, 18'h0F0F0);
    le_ba = 2'b00; b_in = 18'h01234;
    step(2);
    check("R7 hold", a_out, 18'h35A5A);
    ck_ba = 2'b11;
    step(4);
    check("R7 capture", a_out, 18'h01234);
    ck_ba = 2'b00;
    step(3);
  endtask

  task automatic t_contention;
    oe_ab_n = 2'b01; oe_ba_n = 2'b10;
    step(1);
    check("R8 split drives", {14'd0, b_drv, a_drv}, {14'd0, 2'b10, 2'b01});
    check("R11 split no contention", {17'd0, cont}, '0);
    check("R9 full drives", {14'd0, fb_drv, fa_drv}, {14'd0, 2'b00, 2'b11});
    check("R11 full no contention", {17'd0, fcont}, '0);
    oe_ab_n = 2'b10;
    step(1);
    check("R11 lane0 clash", {16'd0, cont, fcont}, 18'd3);
    oe_ab_n = 2'b11; oe_ba_n = 2'b11;
    step(1);
    check("R11 cleared", {16'd0, cont, fcont}, '0);
  endtask

  task automatic t_split;
    le_ab = 2'b01; a_in = 18'h3FE01;
    step(1);
    check("R8 lower follows", b_out, {9'h078, 9'h001});
    check("R9 full follows", fb_out, 18'h3FE01);
    le_ab = 2'b10; a_in = 18'h2AAAA;
    step(1);
    check("R8 upper follows", b_out, {9'h155, 9'h001});
    check("R9 bit1 ignored", fb_out, 18'h3FE01);
    le_ab = 2'b00; ck_ab = 2'b10; a_in = 18'h15555;
    step(4);
    check("R8 upper capture", b_out, {9'h0AA, 9'h001});
    check("R9 full no capture", fb_out, 18'h3FE01);
    ck_ab = 2'b00;
    step(3);
  endtask

  task automatic t_inhibit;
    inhibit = 1'b1; oe_ab_n = 2'b00; oe_ba_n = 2'b00; le_ab = 2'b11; a_in = 18'h11111;
    step(2);
    check("R10 no load", b_out, {9'h0AA, 9'h001});
    check("R10 drives low", {14'd0, b_drv, a_drv}, '0);
    check("R10 no contention", {17'd0, cont}, '0);
    le_ab = 2'b00; ck_ab = 2'b11;
    step(4);
    check("R10 edge ignored", b_out, {9'h0AA, 9'h001});
    inhibit = 1'b0;
    step(3);
    check("R10 edge stays lost", b_out, {9'h0AA, 9'h001});
    le_ab = 2'b11;
    step(1);
    check("R10 resumes", b_out, 18'h11111);
    oe_ab_n = 2'b11; oe_ba_n = 2'b11; ck_ab = 2'b00;
    step(1);
  endtask

  initial begin
    t_reset();
    t_transparent();
    t_hold_capture();
    t_drive_off();
    t_b_to_a();
    t_contention();
    t_split();
    t_inhibit();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule